// File: doc/BRIEF.md
# Cluster Power-Up Sequencer

This block turns on one processor cluster from a fully off state after a single start pulse. It steps through a fixed, ordered list of control actions. It releases the cluster reset and changes the isolation settings. It powers the PLL while its output is still isolated, applies the PLL configuration, and releases the clock sources. It then triggers the clock change, enables the functional clocks, and finally frees the bus, peripheral and L2 soft resets in stages. All timed waits are counted in microsecond ticks, which are derived from a cycles-per-microsecond parameter, so the same RTL can run at any clock frequency.

Before the PLL steps, the sequencer can poll a memory-repair done flag, unless a bypass strap is set. The poll is bounded. If the flag never arrives, the block raises a sticky warning and continues.

The sequencer keeps one "powered" flag per cluster. Cluster 0 is powered from reset. A request for a cluster that is already powered does nothing. A request with an index outside the cluster range produces a one-cycle error pulse. Each accepted run first returns the shared per-run controls to their off values, and then sequences the new cluster.

Top module: `cluster_pwrup_seq`

## Requirements
- R1: After reset, `cl_rst_rel_o` is 0001b (only cluster 0 released) and `pll_out_iso_o` is 1. Every other output is 0.
- R2: A start pulse whose index names a cluster that is already powered changes no output.
- R3: A start pulse with an index of NUM_CLUSTERS or above gives `err_o` high for exactly one cycle. It changes no other output.
- R4: One cycle after acceptance, the `cl_rst_rel_o` bit at the requested index rises. One cycle later, `io_iso_clr_o`, `mem_iso_o` and `dft_iso_o` all rise in the same cycle.
- R5: When `repair_bypass_i` is 0, `repair_done_i` is sampled at the end of each microsecond, for at most REPAIR_US microseconds. If it is seen high, PLL power-up follows with no warning. With the default of 2, a flag already high gives `pll_ldo_o` CYC_PER_US+1 cycles after the isolation step.
- R6: When the repair flag is never seen, `repair_warn_o` rises 2*CYC_PER_US cycles after the isolation step and the sequence continues. When `repair_bypass_i` is 1, no poll takes place and `pll_ldo_o` rises the cycle after the isolation step.
- R7: `pll_ldo_o` and `pll_en_o` rise together while `pll_out_iso_o` is 1. `pll_out_iso_o` falls exactly PLL_ISO_US*CYC_PER_US cycles later (default 2 us).
- R8: `pll_cfg_o` pulses for one cycle, the cycle after the output isolation is removed. `clk_src_rel_o` rises SETTLE_US*CYC_PER_US cycles after that pulse, and `clk_trig_o` pulses SETTLE_US*CYC_PER_US cycles after the clock-source release.
- R9: `fclk_en_o` rises in the cycle in which the trigger pulse ends, and `bus_rst_rel_o` rises one cycle later.
- R10: `periph_rst_rel_o` rises one cycle after `bus_rst_rel_o`, and `l2_rst_rel_o` one cycle after that. Each stays high until the next accepted run.
- R11: `busy_o` rises at acceptance and falls in the cycle in which `l2_rst_rel_o` rises. `done_o` pulses for one cycle in that same cycle. A start while busy is ignored. Once the run ends, the cluster counts as powered, so a later start for it is ignored.
- R12: An accepted run clears the previous run's controls at acceptance. `io_iso_clr_o`, `mem_iso_o`, `dft_iso_o`, the PLL enables, the clock-source, clock-enable and soft-reset releases, and `repair_warn_o` return to 0, and `pll_out_iso_o` returns to 1. Cluster reset releases are never cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| cluster_i | input | IDX_W | Index of the cluster to power |
| repair_bypass_i | input | 1 | Strap: skip the memory-repair poll |
| repair_done_i | input | 1 | Memory repair finished |
| cl_rst_rel_o | output | NUM_CLUSTERS | Per-cluster reset release (sticky) |
| io_iso_clr_o | output | 1 | I/O isolation removed (cluster and both core domains) |
| mem_iso_o | output | 1 | Memory isolation control set |
| dft_iso_o | output | 1 | DFT isolation control set (cluster domain) |
| pll_ldo_o | output | 1 | PLL LDO power enable |
| pll_en_o | output | 1 | PLL power enable |
| pll_out_iso_o | output | 1 | PLL output isolation |
| pll_cfg_o | output | 1 | One-cycle pulse: apply PLL configuration |
| clk_src_rel_o | output | 1 | Crystal and PLL soft resets released |
| clk_trig_o | output | 1 | One-cycle clock-change trigger |
| fclk_en_o | output | 1 | Functional clock enables |
| bus_rst_rel_o | output | 1 | Bus-clock soft resets released |
| periph_rst_rel_o | output | 1 | Temperature-monitor soft reset released |
| l2_rst_rel_o | output | 1 | L2 soft reset released |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle invalid-index pulse |
| repair_warn_o | output | 1 | Repair flag not seen within the poll window |

## Verification
The scoreboard predicts every output edge of each run, together with its exact cycle distance from the previous edge. This catches several kinds of fault:
- A design that removes PLL isolation early, or counts one tick too few or too many, shifts an edge and shows up as a mismatch.
- A design that samples the repair flag at the wrong moment either warns when the flag was present or gets the PLL start time wrong.
- A design that releases the bus before the clock enable, or frees peripheral and L2 in the wrong order, reorders the edges.

The ignored-request cases cover three situations: cluster 0, a cluster that was just powered, and a start pulsed in the middle of a run. A design that acts on any of them produces an edge that nothing predicted. The out-of-range index must produce only the error pulse. The last run must also clear the warning and the controls left over from the earlier run.

// File: rtl/cps_pkg.sv
package cps_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RST,
      ST_ISO,
      ST_REPAIR,
      ST_PLL_ON,
      ST_PLL_WAIT,
      ST_CFG,
      ST_CFG_WAIT,
      ST_SRC_WAIT,
      ST_FCLK,
      ST_BUS,
      ST_PERIPH,
      ST_L2
   } seq_state_e;
endpackage

// File: rtl/cps_us_timer.sv
// Free-running microsecond tick while run is high; restarts from zero when run drops.
module cps_us_timer #(
   parameter int CYC_PER_US = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (CYC_PER_US == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CNT_W = $clog2(CYC_PER_US);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_PER_US - 1);
         logic [CNT_W-1:0] cnt_q;
         assign tick = run && (cnt_q == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (!run)    cnt_q <= '0;
            else if (tick)    cnt_q <= '0;
            else              cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/cps_cluster_tbl.sv
// Per-cluster reset-release and powered flags; cluster 0 starts powered.
module cps_cluster_tbl #(
   parameter int NUM_CLUSTERS = 4,
   parameter int IDX_W        = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rel_we,
   input  logic                    mark_we,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [IDX_W-1:0]        rd_idx,
   output logic [NUM_CLUSTERS-1:0] rel_vec,
   output logic                    rd_on
);
   logic [NUM_CLUSTERS-1:0] on_vec;
   logic [NUM_CLUSTERS-1:0] rd_hit;

   for (genvar i = 0; i < NUM_CLUSTERS; i++) begin : g_cl
      localparam logic BOOT_ON = (i == 0);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rel_vec[i] <= BOOT_ON;
            on_vec[i]  <= BOOT_ON;
         end else begin
            if (rel_we  && wr_idx == IDX_W'(i)) rel_vec[i] <= 1'b1;
            if (mark_we && wr_idx == IDX_W'(i)) on_vec[i]  <= 1'b1;
         end
      end
      assign rd_hit[i] = on_vec[i] && (rd_idx == IDX_W'(i));
   end

   assign rd_on = |rd_hit;
endmodule

// File: rtl/cluster_pwrup_seq.sv
module cluster_pwrup_seq
   import cps_pkg::*;
#(
   parameter int NUM_CLUSTERS = 4,
   parameter int IDX_W        = 3,
   parameter int CYC_PER_US   = 50,
   parameter int REPAIR_US    = 2,
   parameter int PLL_ISO_US   = 2,
   parameter int SETTLE_US    = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [IDX_W-1:0]        cluster_i,
   input  logic                    repair_bypass_i,
   input  logic                    repair_done_i,
   output logic [NUM_CLUSTERS-1:0] cl_rst_rel_o,
   output logic                    io_iso_clr_o,
   output logic                    mem_iso_o,
   output logic                    dft_iso_o,
   output logic                    pll_ldo_o,
   output logic                    pll_en_o,
   output logic                    pll_out_iso_o,
   output logic                    pll_cfg_o,
   output logic                    clk_src_rel_o,
   output logic                    clk_trig_o,
   output logic                    fclk_en_o,
   output logic                    bus_rst_rel_o,
   output logic                    periph_rst_rel_o,
   output logic                    l2_rst_rel_o,
   output logic                    busy_o,
   output logic                    done_o,
   output logic                    err_o,
   output logic                    repair_warn_o
);
   localparam int MAX_US = (REPAIR_US > PLL_ISO_US) ?
                           ((REPAIR_US > SETTLE_US) ? REPAIR_US : SETTLE_US) :
                           ((PLL_ISO_US > SETTLE_US) ? PLL_ISO_US : SETTLE_US);
   localparam int STEP_W = $clog2(MAX_US + 1);
   localparam logic [STEP_W-1:0] REPAIR_LAST = STEP_W'(REPAIR_US - 1);
   localparam logic [STEP_W-1:0] ISO_LAST    = STEP_W'(PLL_ISO_US - 1);
   localparam logic [STEP_W-1:0] SETTLE_LAST = STEP_W'(SETTLE_US - 1);

   // elaboration-time parameter checks
   if (NUM_CLUSTERS < 2)               begin : g_chk_n   $error("NUM_CLUSTERS must be at least 2"); end
   if ((1 << IDX_W) < NUM_CLUSTERS)    begin : g_chk_w   $error("IDX_W too narrow for NUM_CLUSTERS"); end
   if (CYC_PER_US < 1)                 begin : g_chk_c   $error("CYC_PER_US must be positive"); end
   if (REPAIR_US < 1 || SETTLE_US < 1) begin : g_chk_r   $error("wait lengths must be positive"); end
   if (PLL_ISO_US < 2)                 begin : g_chk_p   $error("PLL isolation hold must be at least 2 us"); end

   seq_state_e        state_q;
   logic [IDX_W-1:0]  tgt_q;
   logic [STEP_W-1:0] step_q;
   logic              tick, run, req_on, req_bad;

   assign run = (state_q == ST_REPAIR) || (state_q == ST_PLL_WAIT) ||
                (state_q == ST_CFG_WAIT) || (state_q == ST_SRC_WAIT);
   assign req_bad = (int'(cluster_i) >= NUM_CLUSTERS);

   cps_us_timer #(.CYC_PER_US(CYC_PER_US)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
   );

   cps_cluster_tbl #(.NUM_CLUSTERS(NUM_CLUSTERS), .IDX_W(IDX_W)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .rel_we(state_q == ST_RST), .mark_we(state_q == ST_L2),
      .wr_idx(tgt_q), .rd_idx(cluster_i),
      .rel_vec(cl_rst_rel_o), .rd_on(req_on)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q          <= ST_IDLE;
         tgt_q            <= '0;
         step_q           <= '0;
         io_iso_clr_o     <= 1'b0;
         mem_iso_o        <= 1'b0;
         dft_iso_o        <= 1'b0;
         pll_ldo_o        <= 1'b0;
         pll_en_o         <= 1'b0;
         pll_out_iso_o    <= 1'b1;
         pll_cfg_o        <= 1'b0;
         clk_src_rel_o    <= 1'b0;
         clk_trig_o       <= 1'b0;
         fclk_en_o        <= 1'b0;
         bus_rst_rel_o    <= 1'b0;
         periph_rst_rel_o <= 1'b0;
         l2_rst_rel_o     <= 1'b0;
         busy_o           <= 1'b0;
         done_o           <= 1'b0;
         err_o            <= 1'b0;
         repair_warn_o    <= 1'b0;
      end else begin
         pll_cfg_o  <= 1'b0;
         clk_trig_o <= 1'b0;
         done_o     <= 1'b0;
         err_o      <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (req_bad) begin
                     err_o <= 1'b1;
                  end else if (!req_on) begin
                     tgt_q            <= cluster_i;
                     busy_o           <= 1'b1;
                     io_iso_clr_o     <= 1'b0;
                     mem_iso_o        <= 1'b0;
                     dft_iso_o        <= 1'b0;
                     pll_ldo_o        <= 1'b0;
                     pll_en_o         <= 1'b0;
                     pll_out_iso_o    <= 1'b1;
                     clk_src_rel_o    <= 1'b0;
                     fclk_en_o        <= 1'b0;
                     bus_rst_rel_o    <= 1'b0;
                     periph_rst_rel_o <= 1'b0;
                     l2_rst_rel_o     <= 1'b0;
                     repair_warn_o    <= 1'b0;
                     state_q          <= ST_RST;
                  end
               end
            end
            ST_RST: state_q <= ST_ISO;
            ST_ISO: begin
               io_iso_clr_o <= 1'b1;
               mem_iso_o    <= 1'b1;
               dft_iso_o    <= 1'b1;
               step_q       <= '0;
               state_q      <= repair_bypass_i ? ST_PLL_ON : ST_REPAIR;
            end
            ST_REPAIR: begin
               if (tick) begin
                  if (repair_done_i) begin
                     step_q  <= '0;
                     state_q <= ST_PLL_ON;
                  end else if (step_q == REPAIR_LAST) begin
                     repair_warn_o <= 1'b1;
                     step_q        <= '0;
                     state_q       <= ST_PLL_ON;
                  end else begin
                     step_q <= step_q + 1'b1;
                  end
               end
            end
            ST_PLL_ON: begin
               pll_ldo_o <= 1'b1;
               pll_en_o  <= 1'b1;
               state_q   <= ST_PLL_WAIT;
            end
            ST_PLL_WAIT: begin
               if (tick) begin
                  if (step_q == ISO_LAST) begin
                     pll_out_iso_o <= 1'b0;
                     step_q        <= '0;
                     state_q       <= ST_CFG;
                  end else begin
                     step_q <= step_q + 1'b1;
                  end
               end
            end
            ST_CFG: begin
               pll_cfg_o <= 1'b1;
               state_q   <= ST_CFG_WAIT;
            end
            ST_CFG_WAIT: begin
               if (tick) begin
                  if (step_q == SETTLE_LAST) begin
                     clk_src_rel_o <= 1'b1;
                     step_q        <= '0;
                     state_q       <= ST_SRC_WAIT;
                  end else begin
                     step_q <= step_q + 1'b1;
                  end
               end
            end
            ST_SRC_WAIT: begin
               if (tick) begin
                  if (step_q == SETTLE_LAST) begin
                     clk_trig_o <= 1'b1;
                     step_q     <= '0;
                     state_q    <= ST_FCLK;
                  end else begin
                     step_q <= step_q + 1'b1;
                  end
               end
            end
            ST_FCLK: begin
               fclk_en_o <= 1'b1;
               state_q   <= ST_BUS;
            end
            ST_BUS: begin
               bus_rst_rel_o <= 1'b1;
               state_q       <= ST_PERIPH;
            end
            ST_PERIPH: begin
               periph_rst_rel_o <= 1'b1;
               state_q          <= ST_L2;
            end
            ST_L2: begin
               l2_rst_rel_o <= 1'b1;
               done_o       <= 1'b1;
               busy_o       <= 1'b0;
               state_q      <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
   parameter int NUM_CLUSTERS = 4,
   parameter int IDX_W        = 3,
   parameter int CYC_PER_US   = 50,
   parameter int REPAIR_US    = 2,
   parameter int PLL_ISO_US   = 2,
   parameter int SETTLE_US    = 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start_i,
   input logic [IDX_W-1:0]        cluster_i,
   input logic                    repair_bypass_i,
   input logic                    repair_done_i,
   input logic [NUM_CLUSTERS-1:0] cl_rst_rel_o,
   input logic                    io_iso_clr_o,
   input logic                    mem_iso_o,
   input logic                    dft_iso_o,
   input logic                    pll_ldo_o,
   input logic                    pll_en_o,
   input logic                    pll_out_iso_o,
   input logic                    pll_cfg_o,
   input logic                    clk_src_rel_o,
   input logic                    clk_trig_o,
   input logic                    fclk_en_o,
   input logic                    bus_rst_rel_o,
   input logic                    periph_rst_rel_o,
   input logic                    l2_rst_rel_o,
   input logic                    busy_o,
   input logic                    done_o,
   input logic                    err_o,
   input logic                    repair_warn_o
);
   localparam int ISO_MIN = PLL_ISO_US * CYC_PER_US;
   logic [31:0] iso_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        iso_cnt <= '0;
      else if (!pll_en_o)                iso_cnt <= '0;
      else if (pll_out_iso_o && iso_cnt < 32'(ISO_MIN)) iso_cnt <= iso_cnt + 1;
   end

   a_r1_cluster0_released: assert property (@(posedge clk) disable iff (!rst_n)
      cl_rst_rel_o[0]);
   a_r12_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_rst_rel_o & $past(cl_rst_rel_o)) == $past(cl_rst_rel_o));
   a_r3_err_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !busy_o);
   a_r4_iso_together: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(io_iso_clr_o) |-> (mem_iso_o && dft_iso_o));
   a_r7_power_under_iso: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_en_o) |-> (pll_out_iso_o && pll_ldo_o));
   a_r7_iso_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_out_iso_o) |-> (iso_cnt >= 32'(ISO_MIN)));
   a_r8_src_after_iso: assert property (@(posedge clk) disable iff (!rst_n)
      clk_src_rel_o |-> !pll_out_iso_o);
   a_r9_fclk_after_trig: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fclk_en_o) |-> $past(clk_trig_o));
   a_r9_bus_needs_fclk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_rel_o |-> fclk_en_o);
   a_r10_periph_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
      periph_rst_rel_o |-> bus_rst_rel_o);
   a_r10_l2_after_periph: assert property (@(posedge clk) disable iff (!rst_n)
      l2_rst_rel_o |-> periph_rst_rel_o);
   a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && l2_rst_rel_o));
endmodule

bind cluster_pwrup_seq cps_checker #(
   .NUM_CLUSTERS(NUM_CLUSTERS), .IDX_W(IDX_W), .CYC_PER_US(CYC_PER_US),
   .REPAIR_US(REPAIR_US), .PLL_ISO_US(PLL_ISO_US), .SETTLE_US(SETTLE_US)
) u_chk (.*);

// File: tb/cluster_pwrup_seq_test.sv
`timescale 1ns/1ps
module cluster_pwrup_seq_test;
   localparam int C  = 4;
   localparam int NC = 4;
   localparam int IW = 3;
   localparam int NB = 21;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [IW-1:0] cluster_i = '0;
   logic repair_bypass_i = 1'b0;
   logic repair_done_i = 1'b0;
   logic [NC-1:0] cl_rst_rel_o;
   logic io_iso_clr_o, mem_iso_o, dft_iso_o, pll_ldo_o, pll_en_o, pll_out_iso_o;
   logic pll_cfg_o, clk_src_rel_o, clk_trig_o, fclk_en_o, bus_rst_rel_o;
   logic periph_rst_rel_o, l2_rst_rel_o, busy_o, done_o, err_o, repair_warn_o;

   always #10 clk = ~clk;   // 50 MHz

   cluster_pwrup_seq #(.NUM_CLUSTERS(NC), .IDX_W(IW), .CYC_PER_US(C)) uut (.*);

   typedef struct {
      int bitn;
      bit rise;
      int delta;
      int req;
   } exp_t;

   exp_t        q[$];
   logic [NB-1:0] model;
   logic [NB-1:0] prev;
   int  errors = 0;
   int  checks = 0;
   int  cyc = 0;
   int  last_cyc = 0;
   bit  mon_en = 1'b0;
   bit  finished = 1'b0;

   function automatic logic [NB-1:0] obs();
      return {repair_warn_o, err_o, done_o, busy_o, l2_rst_rel_o, periph_rst_rel_o,
              bus_rst_rel_o, fclk_en_o, clk_trig_o, clk_src_rel_o, pll_cfg_o,
              pll_out_iso_o, pll_en_o, pll_ldo_o, dft_iso_o, mem_iso_o,
              io_iso_clr_o, cl_rst_rel_o};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   task automatic push(input int b, input bit r, input int d, input int req);
      exp_t e;
      e.bitn = b; e.rise = r; e.delta = d; e.req = req;
      q.push_back(e);
      model[b] = r;
   endtask

   // monitor: compare each observed edge with the scoreboard queue
   always @(negedge clk) begin
      if (mon_en) begin
         logic [NB-1:0] cur;
         cyc++;
         cur = obs();
         for (int b = 0; b < NB; b++) begin
            if (cur[b] != prev[b]) begin
               if (q.size() == 0) begin
                  check(1'b0, "R2 unexpected edge on bit", b, -1);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  check(e.bitn == b && e.rise == cur[b],
                        $sformatf("R%0d edge bit/dir", e.req), b*2 + int'(cur[b]), e.bitn*2 + int'(e.rise));
                  if (e.delta >= 0)
                     check(cyc - last_cyc == e.delta,
                           $sformatf("R%0d edge spacing bit %0d", e.req, b), cyc - last_cyc, e.delta);
               end
               last_cyc = cyc;
            end
         end
         prev = cur;
      end
   end

   task automatic pulse_start(input int idx);
      @(negedge clk);
      cluster_i = IW'(idx);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_idle();
      int n;
      n = 0;
      repeat (2) @(negedge clk);
      while (busy_o && n < 5000) begin
         @(negedge clk);
         n++;
      end
      repeat (3) @(negedge clk);
      check(q.size() == 0, "R11 all predicted edges seen", q.size(), 0);
   endtask

   // driver: predicts a full run and pushes it into the scoreboard
   task automatic run_cluster(input int idx, input bit byp, input bit rdone, input int poke);
      int  d;
      bit  first;
      int  shared_bits[11] = '{4, 5, 6, 7, 8, 10, 11, 12, 13, 14, 15};
      repair_bypass_i = byp;
      repair_done_i = rdone;
      first = 1'b1;
      // R12: clears at acceptance, ascending bit order
      for (int k = 0; k < 11; k++) begin
         if (model[shared_bits[k]]) begin
            d = first ? -1 : 0; first = 1'b0;
            push(shared_bits[k], 1'b0, d, 12);
         end
         if (shared_bits[k] == 8 && !model[9]) begin
            d = first ? -1 : 0; first = 1'b0;
            push(9, 1'b1, d, 12);
         end
      end
      if (model[16]) begin d = first ? -1 : 0; first = 1'b0; push(16, 1'b0, d, 12); end
      d = first ? -1 : 0;
      push(17, 1'b1, d, 11);                        // R11 busy rises
      if (model[20]) push(20, 1'b0, 0, 12);
      push(idx, 1'b1, 1, 4);                        // R4 cluster reset release
      push(4, 1'b1, 1, 4); push(5, 1'b1, 0, 4); push(6, 1'b1, 0, 4);
      if (byp)        push(7, 1'b1, 1, 6);          // R6 bypass: no poll
      else if (rdone) push(7, 1'b1, C + 1, 5);      // R5 flag seen at first tick
      else begin
         push(20, 1'b1, 2 * C, 6);                  // R6 warning after window
         push(7, 1'b1, 1, 6);
      end
      push(8, 1'b1, 0, 7);
      push(9, 1'b0, 2 * C, 7);                      // R7 isolation hold
      push(10, 1'b1, 1, 8); push(10, 1'b0, 1, 8);   // R8 config pulse
      push(11, 1'b1, C - 1, 8);
      push(12, 1'b1, C, 8);
      push(12, 1'b0, 1, 9); push(13, 1'b1, 0, 9);   // R9
      push(14, 1'b1, 1, 9);
      push(15, 1'b1, 1, 10); push(16, 1'b1, 1, 10); // R10
      push(17, 1'b0, 0, 11); push(18, 1'b1, 0, 11); push(18, 1'b0, 1, 11);
      pulse_start(idx);
      if (poke >= 0) begin
         repeat (5) @(negedge clk);
         pulse_start(poke);                         // R11 start while busy ignored
      end
      wait_idle();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cl_rst_rel_o == 4'b0001, "R1 cluster releases", int'(cl_rst_rel_o), 1);
      check(pll_out_iso_o == 1'b1, "R1 pll output isolation", int'(pll_out_iso_o), 1);
      check(obs() == NB'(21'h201), "R1 full output vector", int'(obs()), 'h201);
      check(!busy_o && !done_o && !err_o, "R1 status low", int'(busy_o), 0);
      model = obs();
      prev = obs();
      mon_en = 1'b1;

      // R2: cluster 0 already powered
      pulse_start(0);
      repeat (10) @(negedge clk);
      check(q.size() == 0 && obs() == NB'(21'h201), "R2 no change", int'(obs()), 'h201);

      // R3: out-of-range index
      push(19, 1'b1, -1, 3); push(19, 1'b0, 1, 3);
      pulse_start(5);
      repeat (6) @(negedge clk);
      check(q.size() == 0, "R3 error pulse only", q.size(), 0);

      // R5: repair flag present
      run_cluster(1, 1'b0, 1'b1, -1);
      // R6 + R11: repair flag absent, extra start during run
      run_cluster(2, 1'b0, 1'b0, 3);
      check(repair_warn_o == 1'b1, "R6 warning held", int'(repair_warn_o), 1);

      // R11: cluster 1 now powered, request ignored
      pulse_start(1);
      repeat (10) @(negedge clk);
      check(q.size() == 0 && !busy_o, "R11 powered cluster ignored", int'(busy_o), 0);

      // R12 + R6 bypass: clears previous controls and warning
      run_cluster(3, 1'b1, 1'b0, -1);
      check(cl_rst_rel_o == 4'b1111, "R12 releases kept", int'(cl_rst_rel_o), 15);
      check(repair_warn_o == 1'b0, "R12 warning cleared", int'(repair_warn_o), 0);
      check(l2_rst_rel_o == 1'b1, "R10 l2 held", int'(l2_rst_rel_o), 1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule